// File: doc/BRIEF.md
# I2C Acknowledge and SDA Release Controller

This block owns the acknowledge bit and the SDA pull-down of a byte-oriented I2C serial port. It sits beside a shift engine that moves the eight data bits. It watches the SCL and SDA pad levels through a synchronizer and counts SCL falling edges from each transfer start. From that count and four control bits it decides whether SDA is pulled low. The four control bits are automatic acknowledge, acknowledge seen, busy and software acknowledge.

Software sets the wait style with `nine_clk_mode`. With the 9-clock style, the block can answer a received byte with an automatic acknowledge. With the 8-clock style, the bus stalls after the eighth clock, and firmware answers by setting the software acknowledge bit. Busy mode parks the SDA output in release. Hardware cancels it when a transfer starts or an address arrives, but the busy bit that software reads keeps its value.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `sda_pull` is 0.
- R2: With register bit 0 (automatic acknowledge) set and `nine_clk_mode`=1, `sda_pull` is 1 from the 8th SCL falling edge after `xfer_start` until the 9th falling edge, which releases it.
- R3: With `nine_clk_mode`=0, no automatic acknowledge is driven, even when bit 0 is set.
- R4: Hardware never clears bit 0; only a register write changes it.
- R5: Bit 1 (acknowledge seen) becomes 1 when SDA is low at the SCL rising edge that follows the 8th falling edge. It stays 0 when SDA is high there.
- R6: Bit 1 is cleared by `xfer_start` and by `if_enable`=0. Register writes have no effect on it.
- R7: Writing 1 to bit 3 (software acknowledge) makes `sda_pull` 1 within two cycles. The next SCL falling edge clears bit 3 and releases SDA.
- R8: `xfer_start` clears bit 3 only while `if_enable` is 0.
- R9: While busy mode is active, `sda_pull` is 0. Writing 1 to bit 2 activates busy mode, and writing 0 ends it.
- R10: `xfer_start` or `addr_rcvd` ends busy mode. Bit 2 keeps reading 1.
- R11: During the eight data clocks, `sda_pull` follows the inverse of `tx_bit`. After the 8th falling edge, `tx_bit` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pad level, asynchronous |
| sda_in | input | 1 | SDA pad level, asynchronous |
| if_enable | input | 1 | Serial interface enable |
| nine_clk_mode | input | 1 | 1 = 9-clock wait style, 0 = 8-clock wait style |
| xfer_start | input | 1 | One-cycle transfer-start command |
| addr_rcvd | input | 1 | One-cycle address-received pulse |
| tx_bit | input | 1 | Current transmit bit from the shift engine |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Write data: bit0 auto ack, bit1 ignored, bit2 busy, bit3 software ack |
| reg_rdata | output | 4 | Read data, same bit layout, bit1 = acknowledge seen |
| sda_pull | output | 1 | Open-drain pull-down request for SDA |

## Verification
The bound checker watches several rules on every cycle:
- Busy mode silences SDA.
- A start or address pulse cancels busy mode while the busy bit holds.
- A start or a dropped enable clears the acknowledge flag.
- The acknowledge flag rises only after an SCL rising edge.
- The automatic acknowledge bit survives everything but a write.
- The software acknowledge ends on a falling edge.

Only the bench scenarios can show where the acknowledge window lies in the clock sequence, and that the 8-clock style suppresses it. They also show the drive levels for data and software acknowledge, and that writes to the status bit are ignored.

// File: rtl/ackc_pkg.sv
package ackc_pkg;
   localparam int REG_W  = 4;
   localparam int B_AUTO = 0;
   localparam int B_ACK  = 1;
   localparam int B_BUSY = 2;
   localparam int B_SW   = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_ACK  = 2'd2
   } phase_e;
endpackage

// File: rtl/ackc_sync.sv
module ackc_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ackc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ackc_counter.sv
module ackc_counter
   import ackc_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int FRAME_CLKS = 9
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   scl_fall,
   output phase_e phase
);
   localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(FRAME_CLKS - 1);

   logic [CNT_W-1:0] cnt;
   logic             active;

   // falling edges are counted only inside a transfer; the edge that ends the ack clock closes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (start) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (active && scl_fall) begin
         if (cnt == ACK_IDX) active <= 1'b0;
         if (cnt != '1)      cnt    <= cnt + 1'b1;
      end
   end

   always_comb begin
      if (!active)             phase = PH_IDLE;
      else if (cnt == ACK_IDX) phase = PH_ACK;
      else                     phase = PH_DATA;
   end
endmodule

// File: rtl/ackc_regs.sv
module ackc_regs
   import ackc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             if_enable,
   input  logic             xfer_start,
   input  logic             addr_rcvd,
   input  logic             scl_fall,
   input  logic             ack_hit,
   output logic             auto_en,
   output logic             ack_seen,
   output logic             busy_ctl,
   output logic             busy_act,
   output logic             sw_ack
);
   logic wdata_unused;
   assign wdata_unused = wdata[B_ACK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_en  <= 1'b0;
         ack_seen <= 1'b0;
         busy_ctl <= 1'b0;
         busy_act <= 1'b0;
         sw_ack   <= 1'b0;
      end else begin
         if (wr) begin
            auto_en  <= wdata[B_AUTO];
            busy_ctl <= wdata[B_BUSY];
         end

         // clear conditions outrank the detect
         if (xfer_start || !if_enable) ack_seen <= 1'b0;
         else if (ack_hit)             ack_seen <= 1'b1;

         // hardware cancel leaves busy_ctl untouched
         if (xfer_start || addr_rcvd) busy_act <= 1'b0;
         else if (wr)                 busy_act <= wdata[B_BUSY];

         if (wr)                                        sw_ack <= wdata[B_SW];
         else if (scl_fall || (xfer_start && !if_enable)) sw_ack <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl
   import ackc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 4,
   parameter int FRAME_CLKS  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             if_enable,
   input  logic             nine_clk_mode,
   input  logic             xfer_start,
   input  logic             addr_rcvd,
   input  logic             tx_bit,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sda_pull
);
   localparam int N_PADS = 2;

   if (FRAME_CLKS < 2 || FRAME_CLKS >= (1 << CNT_W)) begin : g_bad_frame
      $error("i2c_ack_ctrl: FRAME_CLKS must fit below the counter ceiling");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_ack_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_PADS-1:0] pad_raw, pad_s;
   assign pad_raw = {sda_in, scl_in};

   for (genvar k = 0; k < N_PADS; k++) begin : g_pad
      ackc_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pad_raw[k]),
         .q     (pad_s[k])
      );
   end

   logic scl_s, sda_s, scl_prev, scl_fall, scl_rise;
   assign scl_s = pad_s[0];
   assign sda_s = pad_s[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev <= 1'b1;
      else        scl_prev <= scl_s;
   end
   assign scl_fall = scl_prev & ~scl_s;
   assign scl_rise = ~scl_prev & scl_s;

   phase_e phase;
   ackc_counter #(.CNT_W(CNT_W), .FRAME_CLKS(FRAME_CLKS)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (xfer_start),
      .scl_fall (scl_fall),
      .phase    (phase)
   );

   logic ack_hit, auto_en, ack_seen, busy_ctl, busy_act, sw_ack;
   assign ack_hit = scl_rise && (phase == PH_ACK) && !sda_s;

   ackc_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .wdata      (reg_wdata),
      .if_enable  (if_enable),
      .xfer_start (xfer_start),
      .addr_rcvd  (addr_rcvd),
      .scl_fall   (scl_fall),
      .ack_hit    (ack_hit),
      .auto_en    (auto_en),
      .ack_seen   (ack_seen),
      .busy_ctl   (busy_ctl),
      .busy_act   (busy_act),
      .sw_ack     (sw_ack)
   );

   logic auto_win, data_low, pull_next;
   assign auto_win  = auto_en && nine_clk_mode && (phase == PH_ACK);
   assign data_low  = (phase == PH_DATA) && !tx_bit;
   assign pull_next = !busy_act && (auto_win || data_low || sw_ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_pull <= 1'b0;
      else        sda_pull <= pull_next;
   end

   always_comb begin
      reg_rdata         = '0;
      reg_rdata[B_AUTO] = auto_en;
      reg_rdata[B_ACK]  = ack_seen;
      reg_rdata[B_BUSY] = busy_ctl;
      reg_rdata[B_SW]   = sw_ack;
   end
endmodule

// File: rtl/ackc_checker.sv
module ackc_checker
   import ackc_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   reg_wr,
   input logic   xfer_start,
   input logic   addr_rcvd,
   input logic   if_enable,
   input logic   scl_rise,
   input logic   scl_fall,
   input phase_e phase,
   input logic   auto_en,
   input logic   ack_seen,
   input logic   busy_act,
   input logic   busy_bit,
   input logic   sw_ack,
   input logic   sda_pull
);
   p_auto_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && !reg_wr |=> auto_en);

   p_ack_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_seen) |-> $past(scl_rise));

   p_ack_clr_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !ack_seen);

   p_ack_clr_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !if_enable |=> !ack_seen);

   p_sw_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_ack && scl_fall && !reg_wr |=> !sw_ack);

   p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_act |=> !sda_pull);

   p_busy_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start || addr_rcvd) |=> !busy_act);

   p_busy_bit_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start || addr_rcvd) && !reg_wr |=> $stable(busy_bit));

   p_start_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> phase == PH_DATA);
endmodule

bind i2c_ack_ctrl ackc_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .xfer_start (xfer_start),
   .addr_rcvd  (addr_rcvd),
   .if_enable  (if_enable),
   .scl_rise   (scl_rise),
   .scl_fall   (scl_fall),
   .phase      (phase),
   .auto_en    (auto_en),
   .ack_seen   (ack_seen),
   .busy_act   (busy_act),
   .busy_bit   (reg_rdata[ackc_pkg::B_BUSY]),
   .sw_ack     (sw_ack),
   .sda_pull   (sda_pull)
);

// File: tb/i2c_ack_ctrl_bench.sv
module i2c_ack_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1;
   logic       if_enable = 1'b1, nine_clk_mode = 1'b1;
   logic       xfer_start = 1'b0, addr_rcvd = 1'b0, tx_bit = 1'b1;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       sda_pull;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_ack_ctrl u_i2c_ack_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .if_enable(if_enable), .nine_clk_mode(nine_clk_mode),
      .xfer_start(xfer_start), .addr_rcvd(addr_rcvd), .tx_bit(tx_bit),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sda_pull(sda_pull)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] v);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
      settle(3);
   endtask

   task automatic pulse_start();
      @(negedge clk); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0;
      settle(3);
   endtask

   task automatic pulse_addr();
      @(negedge clk); addr_rcvd = 1'b1;
      @(negedge clk); addr_rcvd = 1'b0;
      settle(3);
   endtask

   task automatic scl_up();   scl_in = 1'b1; settle(SETTLE); endtask
   task automatic scl_down(); scl_in = 1'b0; settle(SETTLE); endtask

   // SCL held low, then a transfer opens and n clock pulses follow
   task automatic open_xfer(input int n);
      scl_down();
      pulse_start();
      for (int i = 0; i < n; i++) begin scl_up(); scl_down(); end
   endtask

   task automatic t_reset();
      check("R1 rdata", reg_rdata, 4'h0);
      check("R1 sda_pull", sda_pull, 1'b0);
   endtask

   task automatic t_auto9();
      nine_clk_mode = 1'b1;
      wr(4'b0001);
      open_xfer(7);
      check("R2 no pull before 8th fall", sda_pull, 1'b0);
      scl_up(); scl_down();
      check("R2 auto ack pull", sda_pull, 1'b1);
      sda_in = 1'b0; settle(3);
      scl_up();
      check("R5 ack seen", reg_rdata[1], 1'b1);
      scl_down(); sda_in = 1'b1;
      check("R2 released at 9th fall", sda_pull, 1'b0);
      check("R4 auto bit kept", reg_rdata[0], 1'b1);
   endtask

   task automatic t_auto8();
      nine_clk_mode = 1'b0;
      open_xfer(8);
      check("R3 no auto ack in 8-clock", sda_pull, 1'b0);
      scl_up();
      check("R5 no ack when SDA high", reg_rdata[1], 1'b0);
      scl_down();
      nine_clk_mode = 1'b1;
   endtask

   task automatic t_swack();
      nine_clk_mode = 1'b0;
      wr(4'b0000);
      open_xfer(8);
      wr(4'b1000);
      check("R7 sw ack pull", sda_pull, 1'b1);
      check("R7 sw bit set", reg_rdata[3], 1'b1);
      scl_up();
      check("R7 held through rise", sda_pull, 1'b1);
      scl_down();
      check("R7 sw bit cleared at fall", reg_rdata[3], 1'b0);
      check("R7 released at fall", sda_pull, 1'b0);
      nine_clk_mode = 1'b1;
   endtask

   task automatic t_swack_start();
      wr(4'b1000);
      pulse_start();
      check("R8 kept while enabled", reg_rdata[3], 1'b1);
      if_enable = 1'b0;
      pulse_start();
      check("R8 cleared while disabled", reg_rdata[3], 1'b0);
      if_enable = 1'b1; settle(2);
   endtask

   task automatic t_ack_clear();
      wr(4'b0000);
      open_xfer(8);
      sda_in = 1'b0; settle(3); scl_up(); sda_in = 1'b1;
      check("R5 ack seen again", reg_rdata[1], 1'b1);
      wr(4'b0000);
      check("R6 write ignored", reg_rdata[1], 1'b1);
      pulse_start();
      check("R6 cleared by start", reg_rdata[1], 1'b0);
      open_xfer(8);
      sda_in = 1'b0; settle(3); scl_up(); sda_in = 1'b1;
      check("R5 ack seen third", reg_rdata[1], 1'b1);
      if_enable = 1'b0; settle(3);
      check("R6 cleared by disable", reg_rdata[1], 1'b0);
      if_enable = 1'b1; scl_down();
   endtask

   task automatic t_busy();
      wr(4'b0001);
      open_xfer(8);
      check("R2 window before busy", sda_pull, 1'b1);
      wr(4'b0101);
      check("R9 busy releases SDA", sda_pull, 1'b0);
      pulse_addr();
      check("R10 address cancels busy", sda_pull, 1'b1);
      check("R10 busy bit stays", reg_rdata[2], 1'b1);
      wr(4'b0101);
      tx_bit = 1'b0;
      pulse_start();
      check("R10 start cancels busy", sda_pull, 1'b1);
      check("R10 busy bit stays after start", reg_rdata[2], 1'b1);
      wr(4'b0101);
      check("R9 busy blocks data", sda_pull, 1'b0);
      wr(4'b0001);
      check("R9 write 0 restores drive", sda_pull, 1'b1);
      tx_bit = 1'b1; settle(3);
   endtask

   task automatic t_tx();
      wr(4'b0000);
      open_xfer(0);
      tx_bit = 1'b0; settle(3);
      check("R11 data low pulls", sda_pull, 1'b1);
      tx_bit = 1'b1; settle(3);
      check("R11 data high releases", sda_pull, 1'b0);
      for (int i = 0; i < 8; i++) begin scl_up(); scl_down(); end
      tx_bit = 1'b0; settle(3);
      check("R11 tx ignored after 8th fall", sda_pull, 1'b0);
      tx_bit = 1'b1; scl_up(); scl_down();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle(2);
      t_reset();
      t_auto9();
      t_auto8();
      t_swack();
      t_swack_start();
      t_ack_clear();
      t_busy();
      t_tx();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end
endmodule